// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block snoops the instruction fetch stream of a processor and flags control-flow errors while the program runs. It treats the program as a set of nodes. A node is a straight run of instruction words whose last word is a branch. For every fetched word the block folds the word into a running signature. When the branch of the node arrives, the block compares the finished signature with a reference value loaded beforehand. It then checks that the next fetched address is one of the two successors that the loaded program graph allows for that node.

Reference data sits in a small table that is searched by node start address. Each entry holds a live bit, the start address, the reference signature, a taken-branch successor and a fall-through successor. The table is filled through a plain write port. When an error is found, a sticky flag and a two-bit cause code are held, and the checker stops observing. A software clear ends the hold. After the clear the checker resynchronises: the next fetch may start any node that is present in the table.

The controller has four states. SEEK waits for any node start. WALK accumulates the words inside a node. LINK waits for the start of a successor node. HOLD keeps an error. The transitions are as follows. SEEK→WALK and LINK→WALK happen on an accepted node start that is not also a branch. SEEK→LINK and LINK→LINK happen on an accepted one-word node whose signature matches. WALK→LINK happens on a matching branch. SEEK, LINK or WALK→HOLD happens on any detected error. HOLD→SEEK happens on a clear.

Top module: `cfsig_watch`

## Requirements
- R1: After reset, err_flag is 0, err_code is 0, every table entry is not live, and the controller is in SEEK.
- R2: In SEEK, a fetch whose address matches no live entry start sets err_flag. It also sets err_code to 3 (unknown node) on the following clock edge.
- R3: The signature restarts from SEED at each node start. For each word w, the signature becomes ({s[SW-2:0],0} ^ (s[SW-1] ? POLY : 0)) ^ w when SIG_MODE=1, and s ^ w when SIG_MODE=0. On the fetch with br_seen high, a result different from the entry's reference signature sets err_code to 1 (signature mismatch).
- R4: After a node ends correctly, the next fetch address must equal that node's taken or fall-through successor. Otherwise err_code becomes 2 (illegal arc). A legal successor raises no error.
- R5: A successor that is legal but matches no live entry sets err_code to 3.
- R6: err_flag and err_code hold their values, and fetches have no effect, until err_clr is high for a clock edge. After that edge, err_flag and err_code are 0 and any live node start is accepted. err_clr has no effect while no error is held.
- R7: A node start fetched together with br_seen is a one-word node. It is compared against its own reference in that same cycle.
- R8: A cycle with fetch_vld low changes nothing, whatever br_seen, fetch_addr and fetch_word carry.
- R9: A write with tbl_live low removes the entry from the search. When several live entries share a start address, the lowest index is used.
- R10: The entry data (reference and successors) used by a node is captured when the node starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | A fetch is seen on the bus this cycle |
| fetch_addr | input | AW | Address of the fetched word |
| fetch_word | input | SW | Fetched instruction word |
| br_seen | input | 1 | The fetched word is the node's branch |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(NODES) | Entry written |
| tbl_live | input | 1 | Live bit for the entry written |
| tbl_start | input | AW | Node start address |
| tbl_sig | input | SW | Reference signature |
| tbl_tgt_a | input | AW | Taken successor start |
| tbl_tgt_b | input | AW | Fall-through successor start |
| err_clr | input | 1 | Software clear of a held error |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 2 | Cause: 0 none, 1 signature, 2 arc, 3 unknown node |

## Verification
The bench builds the block with AW=16, SW=32, NODES=4 and SIG_MODE=1, the shift-register compaction. Four entries are enough to fill the whole table, to load a duplicate start address so the index priority can be seen, and to drop an entry and watch the next match take over. The 16-bit address space makes stray jump addresses and successors that point outside the table easy to place. A short random program graph is walked with injected bit flips and stray jumps, and every fetch is compared with a bench model.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_WALK = 2'd1,
        ST_LINK = 2'd2,
        ST_HOLD = 2'd3
    } cf_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SIG  = 2'd1,
        ERR_ARC  = 2'd2,
        ERR_NODE = 2'd3
    } cf_err_e;

endpackage

// File: rtl/cfsig_table.sv
module cfsig_table #(
    parameter int AW    = 32,
    parameter int SW    = 32,
    parameter int NODES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NODES)-1:0] wr_idx,
    input  logic                     wr_live,
    input  logic [AW-1:0]            wr_start,
    input  logic [SW-1:0]            wr_sig,
    input  logic [AW-1:0]            wr_tgt_a,
    input  logic [AW-1:0]            wr_tgt_b,
    input  logic [AW-1:0]            look_addr,
    output logic                     hit,
    output logic [SW-1:0]            hit_sig,
    output logic [AW-1:0]            hit_tgt_a,
    output logic [AW-1:0]            hit_tgt_b
);
    localparam int IDXW = $clog2(NODES);

    logic [NODES-1:0] match;
    logic [SW-1:0]    ent_sig   [NODES];
    logic [AW-1:0]    ent_tgt_a [NODES];
    logic [AW-1:0]    ent_tgt_b [NODES];

    // One storage slot per entry; the start address is compared in parallel.
    for (genvar g = 0; g < NODES; g++) begin : g_ent
        logic          live_q;
        logic [AW-1:0] start_q;
        logic [SW-1:0] sig_q;
        logic [AW-1:0] ta_q;
        logic [AW-1:0] tb_q;
        logic          sel;

        assign sel = wr_en && (wr_idx == IDXW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= 1'b0;
            end else if (sel) begin
                live_q <= wr_live;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                start_q <= wr_start;
                sig_q   <= wr_sig;
                ta_q    <= wr_tgt_a;
                tb_q    <= wr_tgt_b;
            end
        end

        assign match[g]     = live_q && (start_q == look_addr);
        assign ent_sig[g]   = sig_q;
        assign ent_tgt_a[g] = ta_q;
        assign ent_tgt_b[g] = tb_q;
    end

    // Lowest matching index wins: scan downward so the last hit written is the lowest.
    always_comb begin
        hit       = 1'b0;
        hit_sig   = '0;
        hit_tgt_a = '0;
        hit_tgt_b = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_sig   = ent_sig[i];
                hit_tgt_a = ent_tgt_a[i];
                hit_tgt_b = ent_tgt_b[i];
            end
        end
    end

endmodule

// File: rtl/cfsig_accum.sv
module cfsig_accum #(
    parameter int          SW       = 32,
    parameter int          SIG_MODE = 1,
    parameter logic [31:0] SEED     = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY     = 32'h04C1_1DB7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          restart,
    input  logic [SW-1:0] word,
    output logic [SW-1:0] sig_next
);
    localparam logic [SW-1:0] SEED_W = SW'(SEED);
    localparam logic [SW-1:0] POLY_W = SW'(POLY);

    logic [SW-1:0] sig_q;
    logic [SW-1:0] base;

    // A node start folds its first word into the seed, not into the old value.
    assign base = restart ? SEED_W : sig_q;

    if (SIG_MODE == 0) begin : g_xor
        assign sig_next = base ^ word;
    end else begin : g_misr
        logic [SW-1:0] shifted;
        assign shifted  = {base[SW-2:0], 1'b0} ^ (base[SW-1] ? POLY_W : '0);
        assign sig_next = shifted ^ word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= SEED_W;
        end else if (step_en) begin
            sig_q <= sig_next;
        end
    end

endmodule

// File: rtl/cfsig_ctrl.sv
module cfsig_ctrl
    import cfsig_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_addr,
    input  logic          br_seen,
    input  logic          err_clr,
    input  logic          hit,
    input  logic [SW-1:0] hit_sig,
    input  logic [AW-1:0] hit_tgt_a,
    input  logic [AW-1:0] hit_tgt_b,
    input  logic [SW-1:0] sig_next,
    output logic          restart,
    output logic          step_en,
    output logic          err_flag,
    output logic [1:0]    err_code
);
    cf_state_e     state_q, state_d;
    cf_err_e       fault_code;
    logic          fault_set;
    logic          start_cyc;
    logic          arc_ok;
    logic [SW-1:0] ref_q;
    logic [AW-1:0] ta_q, tb_q;
    logic          flag_q;
    logic [1:0]    code_q;

    assign start_cyc = fetch_vld && ((state_q == ST_SEEK) || (state_q == ST_LINK));
    assign arc_ok    = (fetch_addr == ta_q) || (fetch_addr == tb_q);
    assign restart   = start_cyc;
    assign step_en   = fetch_vld && (state_q != ST_HOLD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and fault decision
    always_comb begin
        state_d    = state_q;
        fault_set  = 1'b0;
        fault_code = ERR_NONE;
        unique case (state_q)
            ST_SEEK, ST_LINK: begin
                if (fetch_vld) begin
                    if ((state_q == ST_LINK) && !arc_ok) begin
                        fault_set  = 1'b1;
                        fault_code = ERR_ARC;
                    end else if (!hit) begin
                        fault_set  = 1'b1;
                        fault_code = ERR_NODE;
                    end else if (br_seen) begin
                        if (sig_next != hit_sig) begin
                            fault_set  = 1'b1;
                            fault_code = ERR_SIG;
                        end else begin
                            state_d = ST_LINK;
                        end
                    end else begin
                        state_d = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (fetch_vld && br_seen) begin
                    if (sig_next != ref_q) begin
                        fault_set  = 1'b1;
                        fault_code = ERR_SIG;
                    end else begin
                        state_d = ST_LINK;
                    end
                end
            end
            ST_HOLD: begin
                if (err_clr) begin
                    state_d = ST_SEEK;
                end
            end
        endcase
        if (fault_set) begin
            state_d = ST_HOLD;
        end
    end

    // Snapshot of the entry that opened the current node
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
            ta_q  <= '0;
            tb_q  <= '0;
        end else if (start_cyc && hit && !fault_set) begin
            ref_q <= hit_sig;
            ta_q  <= hit_tgt_a;
            tb_q  <= hit_tgt_b;
        end
    end

    // Sticky error outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            code_q <= ERR_NONE;
        end else if (fault_set) begin
            flag_q <= 1'b1;
            code_q <= fault_code;
        end else if ((state_q == ST_HOLD) && err_clr) begin
            flag_q <= 1'b0;
            code_q <= ERR_NONE;
        end
    end

    assign err_flag = flag_q;
    assign err_code = code_q;

endmodule

// File: rtl/cfsig_watch.sv
module cfsig_watch #(
    parameter int          AW       = 32,
    parameter int          SW       = 32,
    parameter int          NODES    = 8,
    parameter int          SIG_MODE = 1,
    parameter logic [31:0] SEED     = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY     = 32'h04C1_1DB7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fetch_vld,
    input  logic [AW-1:0]            fetch_addr,
    input  logic [SW-1:0]            fetch_word,
    input  logic                     br_seen,
    input  logic                     tbl_we,
    input  logic [$clog2(NODES)-1:0] tbl_idx,
    input  logic                     tbl_live,
    input  logic [AW-1:0]            tbl_start,
    input  logic [SW-1:0]            tbl_sig,
    input  logic [AW-1:0]            tbl_tgt_a,
    input  logic [AW-1:0]            tbl_tgt_b,
    input  logic                     err_clr,
    output logic                     err_flag,
    output logic [1:0]               err_code
);
    logic          hit;
    logic [SW-1:0] hit_sig;
    logic [AW-1:0] hit_tgt_a, hit_tgt_b;
    logic [SW-1:0] sig_next;
    logic          restart, step_en;

    cfsig_table #(
        .AW    (AW),
        .SW    (SW),
        .NODES (NODES)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_idx    (tbl_idx),
        .wr_live   (tbl_live),
        .wr_start  (tbl_start),
        .wr_sig    (tbl_sig),
        .wr_tgt_a  (tbl_tgt_a),
        .wr_tgt_b  (tbl_tgt_b),
        .look_addr (fetch_addr),
        .hit       (hit),
        .hit_sig   (hit_sig),
        .hit_tgt_a (hit_tgt_a),
        .hit_tgt_b (hit_tgt_b)
    );

    cfsig_accum #(
        .SW       (SW),
        .SIG_MODE (SIG_MODE),
        .SEED     (SEED),
        .POLY     (POLY)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .restart  (restart),
        .word     (fetch_word),
        .sig_next (sig_next)
    );

    cfsig_ctrl #(
        .AW (AW),
        .SW (SW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr),
        .br_seen    (br_seen),
        .err_clr    (err_clr),
        .hit        (hit),
        .hit_sig    (hit_sig),
        .hit_tgt_a  (hit_tgt_a),
        .hit_tgt_b  (hit_tgt_b),
        .sig_next   (sig_next),
        .restart    (restart),
        .step_en    (step_en),
        .err_flag   (err_flag),
        .err_code   (err_code)
    );

endmodule

// File: rtl/cfsig_watch_chk.sv
module cfsig_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_vld,
    input logic       br_seen,
    input logic       err_clr,
    input logic       err_flag,
    input logic [1:0] err_code
);
    // R6: a held error stays, with its cause, until a clear
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_code)));

    // R6: a clear while holding empties flag and code
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && err_clr) |=> (!err_flag && (err_code == 2'd0)));

    // R8: without a fetch no error can appear
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_vld && !err_flag) |=> !err_flag);

    // R3: a signature mismatch only ever follows a branch fetch
    assert_sig_at_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_flag) && (err_code == 2'd1)) |-> $past(br_seen && fetch_vld));

    // R2: flag and cause code agree
    assert_code_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_code != 2'd0));

endmodule

bind cfsig_watch cfsig_watch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_vld (fetch_vld),
    .br_seen   (br_seen),
    .err_clr   (err_clr),
    .err_flag  (err_flag),
    .err_code  (err_code)
);

// File: tb/sim_cfsig_watch.sv
module sim_cfsig_watch;
    localparam int          AW    = 16;
    localparam int          SW    = 32;
    localparam int          NODES = 4;
    localparam logic [31:0] SEED  = 32'hACE1_0001;
    localparam logic [31:0] POLY  = 32'h04C1_1DB7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_vld = 1'b0;
    logic [AW-1:0]   fetch_addr = '0;
    logic [SW-1:0]   fetch_word = '0;
    logic            br_seen = 1'b0;
    logic            tbl_we = 1'b0;
    logic [1:0]      tbl_idx = '0;
    logic            tbl_live = 1'b0;
    logic [AW-1:0]   tbl_start = '0, tbl_tgt_a = '0, tbl_tgt_b = '0;
    logic [SW-1:0]   tbl_sig = '0;
    logic            err_clr = 1'b0;
    logic            err_flag;
    logic [1:0]      err_code;

    always #10 clk = ~clk;

    cfsig_watch #(.AW(AW), .SW(SW), .NODES(NODES), .SIG_MODE(1), .SEED(SEED), .POLY(POLY)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .fetch_word(fetch_word), .br_seen(br_seen), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_live(tbl_live), .tbl_start(tbl_start), .tbl_sig(tbl_sig), .tbl_tgt_a(tbl_tgt_a),
        .tbl_tgt_b(tbl_tgt_b), .err_clr(err_clr), .err_flag(err_flag), .err_code(err_code));

    int n_run = 0, n_fail = 0;

    // Bench model (0 seek, 1 walk, 2 link, 3 hold)
    int            m_st;
    logic [SW-1:0] m_sig, m_ref;
    logic [AW-1:0] m_ta, m_tb;
    logic          m_flag;
    logic [1:0]    m_code;
    logic          t_live [NODES];
    logic [AW-1:0] t_start [NODES], t_ta [NODES], t_tb [NODES];
    logic [SW-1:0] t_sig [NODES];

    // Program used by the random walk
    logic [SW-1:0] pw [NODES][4];
    int            plen [NODES];
    logic [AW-1:0] pstart [NODES], pta [NODES], ptb [NODES];

    function automatic logic [SW-1:0] mstep(logic [SW-1:0] s, logic [SW-1:0] w);
        return ({s[SW-2:0], 1'b0} ^ (s[SW-1] ? SW'(POLY) : '0)) ^ w;
    endfunction

    task automatic model_reset();
        m_st = 0; m_flag = 0; m_code = 0; m_sig = SW'(SEED); m_ref = '0; m_ta = '0; m_tb = '0;
        for (int i = 0; i < NODES; i++) t_live[i] = 1'b0;
    endtask

    task automatic model_err(logic [1:0] c);
        m_flag = 1'b1; m_code = c; m_st = 3;
    endtask

    task automatic model_fetch(logic [AW-1:0] a, logic [SW-1:0] w, logic br);
        logic          h;
        int            hi;
        logic [SW-1:0] s;
        h = 1'b0; hi = 0;
        if (m_st == 0 || m_st == 2) begin
            if (m_st == 2 && a != m_ta && a != m_tb) model_err(2'd2);
            else begin
                for (int i = NODES - 1; i >= 0; i--)
                    if (t_live[i] && t_start[i] == a) begin h = 1'b1; hi = i; end
                if (!h) model_err(2'd3);
                else begin
                    s = mstep(SW'(SEED), w);
                    m_ref = t_sig[hi]; m_ta = t_ta[hi]; m_tb = t_tb[hi];
                    if (br) begin
                        if (s != m_ref) model_err(2'd1); else m_st = 2;
                    end else begin
                        m_sig = s; m_st = 1;
                    end
                end
            end
        end else if (m_st == 1) begin
            s = mstep(m_sig, w);
            m_sig = s;
            if (br) begin
                if (s != m_ref) model_err(2'd1); else m_st = 2;
            end
        end
    endtask

    task automatic check(string lbl);
        n_run++;
        if (err_flag !== m_flag || err_code !== m_code) begin
            n_fail++;
            $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d",
                     lbl, err_flag, err_code, m_flag, m_code);
        end
    endtask

    // All drivers run at the falling edge; checks follow one falling edge later.
    task automatic fetch(logic [AW-1:0] a, logic [SW-1:0] w, logic br, string lbl);
        fetch_vld = 1'b1; fetch_addr = a; fetch_word = w; br_seen = br;
        @(posedge clk); @(negedge clk);
        fetch_vld = 1'b0; br_seen = 1'b0;
        model_fetch(a, w, br);
        check(lbl);
    endtask

    task automatic idle(string lbl);
        fetch_addr = AW'($urandom); fetch_word = $urandom; br_seen = 1'b1;
        @(posedge clk); @(negedge clk);
        br_seen = 1'b0;
        check(lbl);
    endtask

    task automatic clear(string lbl);
        err_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        err_clr = 1'b0;
        if (m_st == 3) begin m_st = 0; m_flag = 1'b0; m_code = 2'd0; end
        check(lbl);
    endtask

    task automatic wr(int idx, logic live, logic [AW-1:0] st, logic [SW-1:0] sg,
                      logic [AW-1:0] ta, logic [AW-1:0] tb);
        tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_live = live; tbl_start = st;
        tbl_sig = sg; tbl_tgt_a = ta; tbl_tgt_b = tb;
        @(posedge clk); @(negedge clk);
        tbl_we = 1'b0;
        t_live[idx] = live; t_start[idx] = st; t_sig[idx] = sg; t_ta[idx] = ta; t_tb[idx] = tb;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check("R1");
    endtask

    task automatic recover();
        fetch(AW'($urandom), $urandom, 1'b1, "R6");
        fetch(AW'($urandom), $urandom, 1'b0, "R6");
        clear("R6");
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        summary();
    end

    initial begin
        logic [SW-1:0] wa, wb, wc, w;
        logic [AW-1:0] nxt;
        int            cur, r, k;
        void'($urandom(32'd2024));
        model_reset();
        @(negedge clk);
        do_reset();

        // R2: empty table, any start is unknown
        fetch(16'h0040, 32'h1111_0000, 1'b0, "R2");
        fetch(16'h0044, 32'h2222_0000, 1'b1, "R6");
        idle("R8");
        clear("R6");
        clear("R6");

        // R9: duplicate start; lower index used, then removed
        wa = 32'hDEAD_0001; wb = 32'hBEEF_0002; wc = 32'h0BAD_CAFE;
        wr(0, 1'b1, 16'h0040, mstep(mstep(SW'(SEED), wa), wb), 16'h0080, 16'h0040);
        wr(1, 1'b1, 16'h0040, 32'h5555_AAAA, 16'h0080, 16'h0040);
        fetch(16'h0040, wa, 1'b0, "R9");
        idle("R8");
        fetch(16'h0044, wb, 1'b1, "R9");
        fetch(16'h0040, wa, 1'b0, "R4");
        fetch(16'h0044, wb, 1'b1, "R3");
        wr(0, 1'b0, 16'h0040, '0, '0, '0);
        fetch(16'h0040, wa, 1'b0, "R9");
        fetch(16'h0044, wb, 1'b1, "R9");
        clear("R6");

        // R7: one-word node, good then corrupted
        wr(2, 1'b1, 16'h0080, mstep(SW'(SEED), wc), 16'h0080, 16'h0080);
        fetch(16'h0080, wc, 1'b1, "R7");
        fetch(16'h0080, wc, 1'b1, "R7");
        fetch(16'h0080, wc ^ 32'h1, 1'b1, "R7");
        clear("R6");

        // R10: snapshot; a table change mid-node does not alter the current node
        fetch(16'h0040, wa, 1'b0, "R10");
        wr(1, 1'b1, 16'h0040, mstep(mstep(SW'(SEED), wa), wb), 16'h0080, 16'h0040);
        fetch(16'h0044, wb, 1'b1, "R10");
        clear("R6");

        // Random walk over a loaded program
        do_reset();
        for (int n = 0; n < NODES; n++) begin
            plen[n] = (n == 1) ? 1 : $urandom_range(4, 1);
            pstart[n] = AW'(16'h0100 * (n + 1));
            for (int j = 0; j < 4; j++) pw[n][j] = $urandom;
            w = SW'(SEED);
            for (int j = 0; j < plen[n]; j++) w = mstep(w, pw[n][j]);
            pta[n] = (n == 3) ? 16'h0F00 : AW'(16'h0100 * ($urandom_range(NODES - 1, 0) + 1));
            ptb[n] = AW'(16'h0100 * (((n + 1) % NODES) + 1));
            wr(n, 1'b1, pstart[n], w, pta[n], ptb[n]);
        end
        cur = 0;
        for (int it = 0; it < 500; it++) begin
            for (int j = 0; j < plen[cur]; j++) begin
                w = pw[cur][j];
                if ($urandom_range(29, 0) == 0) w = w ^ (32'h1 << $urandom_range(SW - 1, 0));
                if ($urandom_range(3, 0) == 0) idle("R8");
                fetch(pstart[cur] + AW'(j * 4), w, (j == plen[cur] - 1), (j == 0) ? "R10" : "R3");
                if (m_flag) break;
            end
            if (m_flag) begin
                recover();
                cur = $urandom_range(NODES - 1, 0);
                continue;
            end
            r = $urandom_range(19, 0);
            if (r == 0) begin
                fetch(16'hF000 | AW'($urandom_range(255, 0)), $urandom, 1'b0, "R4");
                recover();
                cur = $urandom_range(NODES - 1, 0);
                continue;
            end
            nxt = r[0] ? pta[cur] : ptb[cur];
            k = -1;
            for (int n = 0; n < NODES; n++) if (pstart[n] == nxt) k = n;
            if (k < 0) begin
                fetch(nxt, $urandom, 1'b0, "R5");
                recover();
                cur = $urandom_range(NODES - 1, 0);
                continue;
            end
            cur = k;
        end
        summary();
    end

endmodule